// File: doc/BRIEF.md
# Split-Access 32-Bit Timer Register Interface

This block puts a 32-bit free-running up-counter, a 32-bit capture register and a 32-bit compare register behind a 16-bit synchronous peripheral bus. Every 32-bit value moves as two 16-bit bus cycles. Hidden holding registers make those two cycles act as one access. A read of the upper half freezes the matching lower half. A write of the upper half is only staged until the lower half arrives. As a result, software never sees or produces a value that is torn by a carry out of the low half of the running count.

The counter advances by one on every clock. A capture strobe copies the whole count into the capture register in one edge. A one-cycle match pulse is raised when the count equals the compare value. Software always accesses the upper half first and the lower half second. The buffers are shared by all three registers, so the two halves of one access must not be interleaved with an access to another register.

Top module: `split_timer_regs`

## Requirements
- R1: After reset the counter and the capture register are zero, the compare register is all ones, and `rdata_o` and `match_o` are low. The counter then steps once per clock, so five idle clocks after reset release give a count of 5.
- R2: A read (`cs_i` and `rd_i` high) of an upper-half address (0 = counter, 2 = capture, 4 = compare) puts bits 31:16 of that register on `rdata_o` one clock later. In the same clock it copies bits 15:0 of that register into the read buffer.
- R3: A read of a lower-half address (1 = counter, 3 = capture, 5 = compare) returns the read buffer one clock later, not the live register. A counter read therefore stays coherent across a carry out of the low half.
- R4: A write of an upper-half address (0 or 4) loads only the write buffer and leaves the counter and the compare register unchanged.
- R5: A write of address 1 or 5 loads {write buffer, `wdata_i`} into the counter or the compare register in a single edge. A counter load takes priority over the increment, and counting continues from the loaded value.
- R6: Writes to addresses 2 and 3 change neither the capture register nor the write buffer.
- R7: When `capture_i` is high at a clock edge, the capture register takes the full count held just before that edge. This holds even when the same edge loads the counter.
- R8: `match_o` is high for the one clock that follows a clock in which the counter equals the compare register.
- R9: A lower-half read without a preceding upper-half read returns whatever the read buffer holds. A lower-half write without a preceding upper-half write combines the leftover write buffer with the new data.
- R10: With `cs_i` low, the bus has no effect. A read of an unmapped address (6 or 7) returns zero. `rdata_o` holds its value in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 3 | Half-word register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data, valid one clock after the read |
| capture_i | input | 1 | Capture strobe |
| match_o | output | 1 | Compare-match pulse |

## Verification
The capture strobe and a counter lower-half write can land on the same clock edge. The load then replaces the count while the capture copies it. The bench stages a known count, then raises `capture_i` in the same cycle as the address-1 write. It reads both registers back as split pairs. The capture register must show the pre-load count, and the counter must show the loaded value advanced by the idle clocks since. A second overlap is a counter carry between the upper and lower reads, which must not reach the value that is returned.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;

  // Register half-word map; bit 0 selects lower half, bits 2:1 pick the register
  typedef enum logic [2:0] {
    SEL_CNT_HI = 3'd0,
    SEL_CNT_LO = 3'd1,
    SEL_CAP_HI = 3'd2,
    SEL_CAP_LO = 3'd3,
    SEL_CMP_HI = 3'd4,
    SEL_CMP_LO = 3'd5
  } reg_sel_e;

  localparam int unsigned SEL_W = 3;

endpackage

// File: rtl/stt_write_stage.sv
module stt_write_stage #(
  parameter int HALF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stage_i,
  input  logic [HALF_W-1:0] data_i,
  output logic [HALF_W-1:0] buf_o
);

  logic [HALF_W-1:0] buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      buf_q <= '0;
    else if (stage_i) buf_q <= data_i;
  end

  assign buf_o = buf_q;

  // Buffer only changes on an upper-half write
  assert_wbuf_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stage_i |=> $stable(buf_q));
  assert_wbuf_take_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_i |=> buf_q == $past(data_i));

endmodule

// File: rtl/stt_counter_core.sv
module stt_counter_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_load_i,
  input  logic             cmp_load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             cap_stb_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             match_o
);

  logic [CNT_W-1:0] cnt_q, cap_q, cmp_q;
  logic             match_q;

  // Bus load wins over the increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (cnt_load_i) cnt_q <= load_val_i;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cap_q <= '0;
    else if (cap_stb_i) cap_q <= cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cmp_q <= '1;
    else if (cmp_load_i) cmp_q <= load_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= (cnt_q == cmp_q);
  end

  assign cnt_o   = cnt_q;
  assign cap_o   = cap_q;
  assign cmp_o   = cmp_q;
  assign match_o = match_q;

  assert_cnt_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_load_i |=> cnt_q == $past(load_val_i));
  assert_cnt_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_load_i |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_cap_take_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_stb_i |=> cap_q == $past(cnt_q));
  assert_cap_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_stb_i |=> $stable(cap_q));
  assert_cmp_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_load_i |=> $stable(cmp_q));
  assert_match_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == cmp_q) |=> match_o);

endmodule

// File: rtl/stt_read_path.sv
module stt_read_path #(
  parameter int CNT_W = 32,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_hi_i,
  input  logic              rd_lo_i,
  input  logic              rd_zero_i,
  input  logic [CNT_W-1:0]  src_i,
  output logic [HALF_W-1:0] rdata_o
);

  logic [HALF_W-1:0] rbuf_q, rdata_q;

  // Lower half frozen at the moment the upper half is read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rbuf_q <= '0;
    else if (rd_hi_i) rbuf_q <= src_i[HALF_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (rd_hi_i)   rdata_q <= src_i[CNT_W-1:HALF_W];
    else if (rd_lo_i)   rdata_q <= rbuf_q;
    else if (rd_zero_i) rdata_q <= '0;
  end

  assign rdata_o = rdata_q;

  assert_rd_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_hi_i, rd_lo_i, rd_zero_i}));
  assert_lo_from_buf_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i |=> rdata_o == $past(rbuf_q));
  assert_buf_snap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hi_i |=> rbuf_q == $past(src_i[HALF_W-1:0]));
  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_hi_i || rd_lo_i || rd_zero_i) |=> $stable(rdata_o));

endmodule

// File: rtl/split_timer_regs.sv
module split_timer_regs
  import split_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [SEL_W-1:0]  addr_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] rdata_o,
  input  logic              capture_i,
  output logic              match_o
);

  reg_sel_e         sel;
  logic             acc_rd, acc_wr;
  logic             wr_stage, wr_cnt_lo, wr_cmp_lo;
  logic             rd_hi, rd_lo, rd_zero;
  logic [HALF_W-1:0] wbuf;
  logic [CNT_W-1:0] cnt_val, cap_val, cmp_val, src_val;

  assign sel    = reg_sel_e'(addr_i);
  assign acc_rd = cs_i & rd_i;
  assign acc_wr = cs_i & wr_i;

  // Capture addresses are read-only: no staging, no load
  assign wr_stage  = acc_wr & ((sel == SEL_CNT_HI) | (sel == SEL_CMP_HI));
  assign wr_cnt_lo = acc_wr & (sel == SEL_CNT_LO);
  assign wr_cmp_lo = acc_wr & (sel == SEL_CMP_LO);

  always_comb begin
    rd_hi   = 1'b0;
    rd_lo   = 1'b0;
    rd_zero = 1'b0;
    src_val = '0;
    unique case (addr_i[2:1])
      2'b00:   src_val = cnt_val;
      2'b01:   src_val = cap_val;
      2'b10:   src_val = cmp_val;
      default: src_val = '0;
    endcase
    if (acc_rd) begin
      if (addr_i[2:1] == 2'b11) rd_zero = 1'b1;
      else if (addr_i[0])       rd_lo   = 1'b1;
      else                      rd_hi   = 1'b1;
    end
  end

  stt_write_stage #(.HALF_W(HALF_W)) u_wstage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stage_i (wr_stage),
    .data_i  (wdata_i),
    .buf_o   (wbuf)
  );

  stt_counter_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_load_i (wr_cnt_lo),
    .cmp_load_i (wr_cmp_lo),
    .load_val_i ({wbuf, wdata_i}),
    .cap_stb_i  (capture_i),
    .cnt_o      (cnt_val),
    .cap_o      (cap_val),
    .cmp_o      (cmp_val),
    .match_o    (match_o)
  );

  stt_read_path #(.CNT_W(CNT_W)) u_rpath (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_hi_i   (rd_hi),
    .rd_lo_i   (rd_lo),
    .rd_zero_i (rd_zero),
    .src_i     (src_val),
    .rdata_o   (rdata_o)
  );

  assert_cap_ro_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr && addr_i[2:1] == 2'b01 && !capture_i) |=> $stable(cap_val));
  assert_hi_no_update_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stage |=> $stable(cmp_val));
  assert_cs_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |-> !(wr_stage || wr_cnt_lo || wr_cmp_lo || rd_hi || rd_lo || rd_zero));
  assert_cmp_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmp_lo |=> cmp_val == {$past(wbuf), $past(wdata_i)});

endmodule

// File: tb/split_timer_regs_tb_top.sv
module split_timer_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs = 1'b0, rd = 1'b0, wr = 1'b0, cap = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        match;
  int          checks = 0;
  int          errors = 0;
  logic [15:0] got;

  always #5 clk = ~clk;

  split_timer_regs dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .cs_i      (cs),
    .rd_i      (rd),
    .wr_i      (wr),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .capture_i (cap),
    .match_o   (match)
  );

  typedef struct packed {
    logic        cs, rd, wr;
    logic [2:0]  a;
    logic [15:0] d;
    logic        cap;
    logic        chk;
    logic [15:0] exp;
    logic        em;
    logic [3:0]  req;
  } vec_t;

  localparam int N_VEC = 23;
  localparam vec_t TBL [N_VEC] = '{
    '{1'b1,1'b0,1'b1,3'd0,16'h1234,1'b0,1'b0,16'h0000,1'b0,4'd5},  // R5 stage upper
    '{1'b1,1'b0,1'b1,3'd1,16'hFFFD,1'b0,1'b0,16'h0000,1'b0,4'd5},  // R5 load 0x1234FFFD
    '{1'b1,1'b1,1'b0,3'd0,16'h0000,1'b0,1'b1,16'h1234,1'b0,4'd2},  // R2 read upper
    '{1'b0,1'b0,1'b0,3'd0,16'h0000,1'b0,1'b1,16'h1234,1'b0,4'd10}, // R10 hold
    '{1'b0,1'b0,1'b0,3'd0,16'h0000,1'b0,1'b1,16'h1234,1'b0,4'd10}, // R10 hold, carry
    '{1'b1,1'b1,1'b0,3'd1,16'h0000,1'b0,1'b1,16'hFFFD,1'b0,4'd3},  // R3 frozen low
    '{1'b1,1'b0,1'b1,3'd4,16'h1235,1'b0,1'b0,16'h0000,1'b0,4'd4},  // R4 stage cmp
    '{1'b1,1'b0,1'b1,3'd5,16'h0006,1'b0,1'b0,16'h0000,1'b0,4'd5},  // R5 cmp=0x12350006
    '{1'b1,1'b1,1'b0,3'd4,16'h0000,1'b0,1'b1,16'h1235,1'b0,4'd5},  // R5
    '{1'b1,1'b1,1'b0,3'd5,16'h0000,1'b0,1'b1,16'h0006,1'b0,4'd5},  // R5
    '{1'b0,1'b0,1'b0,3'd0,16'h0000,1'b0,1'b1,16'h0006,1'b0,4'd8},  // R8 equal now
    '{1'b0,1'b0,1'b0,3'd0,16'h0000,1'b0,1'b1,16'h0006,1'b1,4'd8},  // R8 pulse
    '{1'b0,1'b0,1'b0,3'd0,16'h0000,1'b0,1'b1,16'h0006,1'b0,4'd8},  // R8 one cycle
    '{1'b0,1'b0,1'b0,3'd0,16'h0000,1'b1,1'b0,16'h0000,1'b0,4'd7},  // R7 capture 0x12350008
    '{1'b1,1'b0,1'b1,3'd2,16'hDEAD,1'b0,1'b0,16'h0000,1'b0,4'd6},  // R6 ignored
    '{1'b1,1'b0,1'b1,3'd3,16'hBEEF,1'b0,1'b0,16'h0000,1'b0,4'd6},  // R6 ignored
    '{1'b1,1'b1,1'b0,3'd2,16'h0000,1'b0,1'b1,16'h1235,1'b0,4'd7},  // R7
    '{1'b1,1'b1,1'b0,3'd3,16'h0000,1'b0,1'b1,16'h0008,1'b0,4'd7},  // R7
    '{1'b1,1'b0,1'b1,3'd1,16'h0100,1'b0,1'b0,16'h0000,1'b0,4'd9},  // R9 leftover wbuf
    '{1'b1,1'b1,1'b0,3'd0,16'h0000,1'b0,1'b1,16'h1235,1'b0,4'd9},  // R9 / R6 wbuf kept
    '{1'b1,1'b1,1'b0,3'd1,16'h0000,1'b0,1'b1,16'h0100,1'b0,4'd9},  // R9
    '{1'b0,1'b1,1'b0,3'd0,16'h0000,1'b0,1'b1,16'h0100,1'b0,4'd10}, // R10 cs low
    '{1'b1,1'b1,1'b0,3'd7,16'h0000,1'b0,1'b1,16'h0000,1'b0,4'd10}  // R10 unmapped
  };

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  // Drive one bus cycle from a negedge, return rdata sampled at the next negedge
  task automatic bus(input logic c, input logic r, input logic w, input logic [2:0] a,
                     input logic [15:0] d, input logic s, output logic [15:0] q);
    cs = c; rd = r; wr = w; addr = a; wdata = d; cap = s;
    @(posedge clk);
    @(negedge clk);
    cs = 1'b0; rd = 1'b0; wr = 1'b0; cap = 1'b0;
    q = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check16("R1 rdata in reset", rdata, 16'h0000);
    check16("R1 match in reset", {15'd0, match}, 16'h0000);
    rst_ni = 1'b1;
    for (int i = 0; i < 5; i++) bus(0, 0, 0, 3'd0, 16'h0, 0, got);
    bus(1, 1, 0, 3'd0, 16'h0, 0, got); check16("R1 cnt hi", got, 16'h0000);
    bus(1, 1, 0, 3'd1, 16'h0, 0, got); check16("R1 cnt lo", got, 16'h0005);
    bus(1, 1, 0, 3'd4, 16'h0, 0, got); check16("R1 cmp hi", got, 16'hFFFF);
    bus(1, 1, 0, 3'd5, 16'h0, 0, got); check16("R1 cmp lo", got, 16'hFFFF);
    bus(1, 1, 0, 3'd2, 16'h0, 0, got); check16("R1 cap hi", got, 16'h0000);
    bus(1, 1, 0, 3'd3, 16'h0, 0, got); check16("R1 cap lo", got, 16'h0000);
    check16("R1 match idle", {15'd0, match}, 16'h0000);

    for (int i = 0; i < N_VEC; i++) begin
      bus(TBL[i].cs, TBL[i].rd, TBL[i].wr, TBL[i].a, TBL[i].d, TBL[i].cap, got);
      if (TBL[i].chk) check16($sformatf("R%0d row %0d rdata", TBL[i].req, i), got, TBL[i].exp);
      check16($sformatf("R%0d row %0d match", TBL[i].req, i), {15'd0, match}, {15'd0, TBL[i].em});
    end

    // R4: upper-half write alone leaves compare unchanged
    bus(1, 0, 1, 3'd4, 16'h0042, 0, got);
    bus(1, 1, 0, 3'd4, 16'h0, 0, got); check16("R4 cmp hi kept", got, 16'h1235);
    bus(1, 1, 0, 3'd5, 16'h0, 0, got); check16("R4 cmp lo kept", got, 16'h0006);

    // R7 with R5: capture and counter load on the same edge
    bus(1, 0, 1, 3'd0, 16'h0000, 0, got);
    bus(1, 0, 1, 3'd1, 16'h0010, 0, got);
    bus(1, 0, 1, 3'd0, 16'h0770, 0, got);
    bus(1, 0, 1, 3'd1, 16'h0000, 1, got);
    bus(1, 1, 0, 3'd2, 16'h0, 0, got); check16("R7 cap hi pre-load", got, 16'h0000);
    bus(1, 1, 0, 3'd3, 16'h0, 0, got); check16("R7 cap lo pre-load", got, 16'h0011);
    bus(1, 1, 0, 3'd0, 16'h0, 0, got); check16("R5 cnt hi loaded", got, 16'h0770);
    bus(1, 1, 0, 3'd1, 16'h0, 0, got); check16("R5 cnt lo resumed", got, 16'h0002);
    check16("R8 no match", {15'd0, match}, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule